// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller-style system keep running while the processor sleeps. Software picks one of eight mode codes and sets a permission bit. A single-cycle sleep strobe then gates the domains that belong to that mode. The gated domains are the processor, program memory, peripheral I/O, ADC, asynchronous timer and the main oscillator.

While the system sleeps, the block watches twelve wake request lines. Each line is synchronized and must stay high for a set number of cycles before it counts. The block accepts only the lines that the sleeping mode allows. An accepted request starts a wake-up wait. The length of the wait depends on the mode:

- No wait in the modes that leave the oscillator running unattended.
- A fixed six cycles in the two standby modes.
- A start-up delay taken from a static configuration input in the modes that stop the oscillator.

When the wait ends, every clock is released and a one-cycle resume pulse is raised. The block also drives an ADC start strobe and a comparator shut-off output.

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: After reset all six clock enables are 1, and `comp_off`, `adc_start` and `resume` are 0.
- R2: A sleep strobe seen while `sleep_en` is 0 changes no output.
- R3: Mode codes 000, 100 and 101 (idle) gate only the processor and program-memory clocks.
- R4: Mode 001 (ADC quiet) also gates the I/O clock. The ADC, asynchronous-timer and oscillator enables stay 1.
- R5: Mode 010 (deep off) clears all six enables, including `osc_en`. Mode 110 (standby) does the same except that `osc_en` stays 1.
- R6: Modes 011 (timer keep-alive) and 111 (extended standby) clear every enable except `clk_en_async`, which follows `async_sel`. `osc_en` is 0 in 011 and 1 in 111.
- R7: Entering mode 000, 001, 100 or 101 with `adc_on` high raises `adc_start` for exactly one cycle. No other entry raises it.
- R8: The wake line indices are:
  - 0 external reset
  - 1 watchdog reset
  - 2 brown-out reset
  - 3 two-wire address match
  - 4 level line 0
  - 5 level line 1
  - 6 external line 2
  - 7 ADC done
  - 8 memory ready
  - 9 timer overflow
  - 10 timer compare
  - 11 any other interrupt

  Idle accepts all twelve lines. Mode 001 accepts lines 0 to 10. Modes 010 and 110 accept lines 0 to 6.
- R9: Modes 011 and 111 accept lines 0 to 6. They also accept line 9 when `async_sel`, `tmr_ovf_ie` and `gie` are all 1, and line 10 when `async_sel`, `tmr_cmp_ie` and `gie` are all 1.
- R10: A wake line passes a 2-flop synchronizer and must then stay high for 3 consecutive cycles before it is accepted. A shorter pulse is ignored.
- R11: Clocks are released D+1 cycles after a request is accepted:
  - D=0 in modes 000, 001, 100 and 101.
  - D=6 in modes 110 and 111.
  - D=`startup_dly` in modes 010 and 011.

  `osc_en` is 1 throughout the wait.
- R12: `resume` is a single-cycle pulse, raised in the first cycle in which the clocks are released again.
- R13: If an accepted request is already pending when a valid sleep strobe arrives, no clock is gated and `resume` pulses in the next cycle.
- R14: `comp_off` is 1 exactly while the block is asleep or waking in mode 010, 011, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sleep mode code |
| sleep_en | input | 1 | Sleep permission |
| sleep_req | input | 1 | Single-cycle sleep strobe |
| adc_on | input | 1 | ADC is enabled |
| async_sel | input | 1 | Asynchronous timer runs from its own clock |
| tmr_ovf_ie | input | 1 | Timer overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Timer compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| wake_req | input | 12 | Wake request lines, indexed as in R8 |
| startup_dly | input | 8 | Oscillator start-up wait in cycles |
| clk_en_cpu | output | 1 | Processor clock enable |
| clk_en_flash | output | 1 | Program memory clock enable |
| clk_en_io | output | 1 | Peripheral I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | One-cycle ADC conversion start |
| comp_off | output | 1 | Comparator shut-off |
| resume | output | 1 | One-cycle wake completion pulse |

## Verification
Every mode code is entered, including the two reserved ones. A source outside the mode's allowed set is held and must not wake the block; a source inside the set must. This separates the accept masks of the modes. Wake latency is measured in cycles for three cases: the no-wait modes, the six-cycle standby modes, and the start-up-delay modes with both a non-zero and a zero delay. A pulse one cycle too short is set against one of full length to locate the filter threshold. A request that is already pending at the sleep strobe, and a strobe sent without permission, exercise the two paths that never gate a clock.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam int NSRC = 12;

   // wake line indices
   localparam int WK_EXT_RST  = 0;
   localparam int WK_WDT_RST  = 1;
   localparam int WK_BOD_RST  = 2;
   localparam int WK_TWI_HIT  = 3;
   localparam int WK_LVL0     = 4;
   localparam int WK_LVL1     = 5;
   localparam int WK_EDGE2    = 6;
   localparam int WK_ADC_DONE = 7;
   localparam int WK_MEM_RDY  = 8;
   localparam int WK_TMR_OVF  = 9;
   localparam int WK_TMR_CMP  = 10;
   localparam int WK_ANY_IRQ  = 11;

   typedef enum logic [2:0] {
      MD_IDLE  = 3'b000,
      MD_QUIET = 3'b001,
      MD_OFF   = 3'b010,
      MD_KEEP  = 3'b011,
      MD_RSV4  = 3'b100,
      MD_RSV5  = 3'b101,
      MD_STBY  = 3'b110,
      MD_XSTBY = 3'b111
   } slp_mode_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WAKE  = 2'd2
   } slp_state_e;

   typedef struct packed {
      logic cpu;
      logic flash;
      logic io;
      logic adc;
      logic asyn;
      logic osc;
   } clk_gate_t;

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter #(
   parameter int NSRC        = 12,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   output logic [NSRC-1:0] acc
);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [SYNC_STAGES-1:0] sh;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2:0], req[i]};
      end

      if (HOLD_CYC == 0) begin : g_direct
         assign acc[i] = sh[SYNC_STAGES-1];
      end else begin : g_hold
         localparam int HW = $clog2(HOLD_CYC + 1);
         localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC);
         logic [HW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (!sh[SYNC_STAGES-1]) cnt <= '0;
            else if (cnt != HMAX)        cnt <= cnt + 1'b1;
         end

         assign acc[i] = (cnt == HMAX);
      end
   end

endmodule

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
   import slp_pkg::*;
(
   input  logic [2:0]      mode,
   input  logic            async_sel,
   input  logic            tmr_ovf_ie,
   input  logic            tmr_cmp_ie,
   input  logic            gie,
   output clk_gate_t       gate,
   output logic [NSRC-1:0] mask,
   output logic            comp_off,
   output logic            adc_kick,
   output logic            osc_stopped,
   output logic            fixed_wake
);

   logic [NSRC-1:0] base_m, quiet_m, idle_m, keep_m;

   always_comb begin
      base_m = '0;
      base_m[WK_EXT_RST] = 1'b1;
      base_m[WK_WDT_RST] = 1'b1;
      base_m[WK_BOD_RST] = 1'b1;
      base_m[WK_TWI_HIT] = 1'b1;
      base_m[WK_LVL0]    = 1'b1;
      base_m[WK_LVL1]    = 1'b1;
      base_m[WK_EDGE2]   = 1'b1;

      quiet_m = base_m;
      quiet_m[WK_ADC_DONE] = 1'b1;
      quiet_m[WK_MEM_RDY]  = 1'b1;
      quiet_m[WK_TMR_OVF]  = 1'b1;
      quiet_m[WK_TMR_CMP]  = 1'b1;

      idle_m = quiet_m;
      idle_m[WK_ANY_IRQ] = 1'b1;

      keep_m = base_m;
      keep_m[WK_TMR_OVF] = async_sel & tmr_ovf_ie & gie;
      keep_m[WK_TMR_CMP] = async_sel & tmr_cmp_ie & gie;
   end

   always_comb begin
      gate        = '0;
      mask        = base_m;
      comp_off    = 1'b0;
      adc_kick    = 1'b0;
      osc_stopped = 1'b0;
      fixed_wake  = 1'b0;
      case (mode)
         MD_QUIET: begin
            gate.adc  = 1'b1;
            gate.asyn = 1'b1;
            gate.osc  = 1'b1;
            mask      = quiet_m;
            adc_kick  = 1'b1;
         end
         MD_OFF: begin
            comp_off    = 1'b1;
            osc_stopped = 1'b1;
         end
         MD_KEEP: begin
            gate.asyn   = async_sel;
            mask        = keep_m;
            comp_off    = 1'b1;
            osc_stopped = 1'b1;
         end
         MD_STBY: begin
            gate.osc   = 1'b1;
            comp_off   = 1'b1;
            fixed_wake = 1'b1;
         end
         MD_XSTBY: begin
            gate.asyn  = async_sel;
            gate.osc   = 1'b1;
            mask       = keep_m;
            comp_off   = 1'b1;
            fixed_wake = 1'b1;
         end
         default: begin
            // idle and the two reserved codes
            gate.io   = 1'b1;
            gate.adc  = 1'b1;
            gate.asyn = 1'b1;
            gate.osc  = 1'b1;
            mask      = idle_m;
            adc_kick  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         run,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = run && (cnt == W'(1));

endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int HOLD_CYC      = 3,
   parameter int DLY_W         = 8,
   parameter int STBY_WAKE_CYC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic             sleep_en,
   input  logic             sleep_req,
   input  logic             adc_on,
   input  logic             async_sel,
   input  logic             tmr_ovf_ie,
   input  logic             tmr_cmp_ie,
   input  logic             gie,
   input  logic [NSRC-1:0]  wake_req,
   input  logic [DLY_W-1:0] startup_dly,
   output logic             clk_en_cpu,
   output logic             clk_en_flash,
   output logic             clk_en_io,
   output logic             clk_en_adc,
   output logic             clk_en_async,
   output logic             osc_en,
   output logic             adc_start,
   output logic             comp_off,
   output logic             resume
);

   localparam logic [DLY_W-1:0] STBY_V = DLY_W'(STBY_WAKE_CYC);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HOLD_CYC < 0) begin : g_bad_hold
      $error("HOLD_CYC must not be negative");
   end
   if (STBY_WAKE_CYC < 1 || STBY_WAKE_CYC >= (1 << DLY_W)) begin : g_bad_stby
      $error("STBY_WAKE_CYC must fit in DLY_W bits and be non-zero");
   end

   slp_state_e      state;
   logic [2:0]      mode_q;
   logic [NSRC-1:0] acc;

   clk_gate_t       live_gate, q_gate;
   logic [NSRC-1:0] live_mask, q_mask;
   logic            live_comp, q_comp;
   logic            live_kick, q_kick;
   logic            live_ostop, q_ostop;
   logic            live_fix, q_fix;

   logic            live_hit, slp_hit;
   logic [DLY_W-1:0] dly;
   logic            tmr_load, tmr_done;

   slp_wake_filter #(
      .NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)
   ) u_filter (
      .clk(clk), .rst_n(rst_n), .req(wake_req), .acc(acc)
   );

   slp_mode_decode u_dec_live (
      .mode(mode_sel), .async_sel(async_sel), .tmr_ovf_ie(tmr_ovf_ie),
      .tmr_cmp_ie(tmr_cmp_ie), .gie(gie), .gate(live_gate), .mask(live_mask),
      .comp_off(live_comp), .adc_kick(live_kick), .osc_stopped(live_ostop),
      .fixed_wake(live_fix)
   );

   slp_mode_decode u_dec_held (
      .mode(mode_q), .async_sel(async_sel), .tmr_ovf_ie(tmr_ovf_ie),
      .tmr_cmp_ie(tmr_cmp_ie), .gie(gie), .gate(q_gate), .mask(q_mask),
      .comp_off(q_comp), .adc_kick(q_kick), .osc_stopped(q_ostop),
      .fixed_wake(q_fix)
   );

   assign live_hit = |(acc & live_mask);
   assign slp_hit  = |(acc & q_mask);

   always_comb begin
      if (q_ostop)    dly = startup_dly;
      else if (q_fix) dly = STBY_V;
      else            dly = '0;
   end

   assign tmr_load = (state == ST_SLEEP) && slp_hit;

   slp_wake_timer #(.W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(dly),
      .run(state == ST_WAKE), .done(tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         mode_q    <= MD_IDLE;
         resume    <= 1'b0;
         adc_start <= 1'b0;
      end else begin
         resume    <= 1'b0;
         adc_start <= 1'b0;
         unique case (state)
            ST_RUN: begin
               if (sleep_req && sleep_en) begin
                  if (live_hit) begin
                     resume <= 1'b1;
                  end else begin
                     state     <= ST_SLEEP;
                     mode_q    <= mode_sel;
                     adc_start <= adc_on & live_kick;
                  end
               end
            end
            ST_SLEEP: begin
               if (slp_hit) begin
                  if (dly == '0) begin
                     state  <= ST_RUN;
                     resume <= 1'b1;
                  end else begin
                     state <= ST_WAKE;
                  end
               end
            end
            ST_WAKE: begin
               if (tmr_done) begin
                  state  <= ST_RUN;
                  resume <= 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   logic unused_live;
   assign unused_live = ^{live_gate, live_comp, live_ostop, live_fix, q_kick};

   always_comb begin
      if (state == ST_RUN) begin
         clk_en_cpu   = 1'b1;
         clk_en_flash = 1'b1;
         clk_en_io    = 1'b1;
         clk_en_adc   = 1'b1;
         clk_en_async = 1'b1;
         osc_en       = 1'b1;
         comp_off     = 1'b0;
      end else begin
         clk_en_cpu   = q_gate.cpu;
         clk_en_flash = q_gate.flash;
         clk_en_io    = q_gate.io;
         clk_en_adc   = q_gate.adc;
         clk_en_async = q_gate.asyn;
         osc_en       = q_gate.osc | (state == ST_WAKE);
         comp_off     = q_comp;
      end
   end

endmodule

// File: rtl/slp_clkgate_chk.sv
module slp_clkgate_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_req,
   input logic sleep_en,
   input logic clk_en_cpu,
   input logic clk_en_flash,
   input logic clk_en_io,
   input logic clk_en_adc,
   input logic osc_en,
   input logic comp_off,
   input logic adc_start,
   input logic resume
);

   // R2: the processor clock only stops after a permitted strobe
   a_r2_gate_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_cpu) |-> $past(sleep_req && sleep_en));

   // R3: program memory never outlives a stopped I/O domain
   a_r3_io_off_flash_off: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_io |-> !clk_en_flash);

   // R5: oscillator off means the whole synchronous side is off
   a_r5_osc_off_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!clk_en_io && !clk_en_adc && !clk_en_cpu && comp_off));

   // R7: conversion start is a single pulse with the ADC clock alive
   a_r7_adc_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);
   a_r7_adc_start_clocked: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (clk_en_adc && !clk_en_cpu));

   // R12: resume is one cycle long and the processor runs during it
   a_r12_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);
   a_r12_resume_running: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> (clk_en_cpu && clk_en_io && osc_en && !comp_off));

   // R14: comparator shut-off only while the processor is stopped
   a_r14_comp_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      comp_off |-> (!clk_en_cpu && !clk_en_io));

endmodule

bind slp_clkgate_ctrl slp_clkgate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
   .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
   .clk_en_adc(clk_en_adc), .osc_en(osc_en), .comp_off(comp_off),
   .adc_start(adc_start), .resume(resume)
);

// File: tb/test_slp_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_slp_clkgate_ctrl;

   localparam int SYNC = 2;
   localparam int HOLD = 3;
   localparam int STBY = 6;
   localparam int BASE = SYNC + HOLD + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic        sleep_en = 1'b0, sleep_req = 1'b0, adc_on = 1'b0;
   logic        async_sel = 1'b0, tmr_ovf_ie = 1'b0, tmr_cmp_ie = 1'b0, gie = 1'b0;
   logic [11:0] wake_req = '0;
   logic [7:0]  startup_dly = 8'd0;
   logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en;
   logic adc_start, comp_off, resume;

   always #10 clk = ~clk;

   slp_clkgate_ctrl i_slp_clkgate_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
      .sleep_req(sleep_req), .adc_on(adc_on), .async_sel(async_sel),
      .tmr_ovf_ie(tmr_ovf_ie), .tmr_cmp_ie(tmr_cmp_ie), .gie(gie),
      .wake_req(wake_req), .startup_dly(startup_dly),
      .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
      .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_en(osc_en),
      .adc_start(adc_start), .comp_off(comp_off), .resume(resume)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_state = 0;   // 0 running, 1 asleep, 2 waking
   int          m_mode = 0;
   int          m_wait = 0;
   int          m_hold[12];
   logic [11:0] m_pipe[$];
   bit          m_adc = 0, m_res = 0;

   function automatic int norm(input logic [2:0] m);
      return (m == 3'd4 || m == 3'd5) ? 0 : int'(m);
   endfunction

   function automatic logic [11:0] allowed(input int m);
      logic [11:0] v;
      case (m)
         0: v = 12'hFFF;
         1: v = 12'h7FF;
         2, 6: v = 12'h07F;
         default: begin
            v = 12'h07F;
            v[9]  = async_sel & tmr_ovf_ie & gie;
            v[10] = async_sel & tmr_cmp_ie & gie;
         end
      endcase
      return v;
   endfunction

   // expected {cpu,flash,io,adc,async,osc,adc_start,comp_off,resume}
   function automatic logic [8:0] expect_out();
      logic [5:0] g;
      bit cmp;
      if (m_state == 0) return {6'b111111, m_adc, 1'b0, m_res};
      case (m_mode)
         0: g = 6'b001111;
         1: g = 6'b000111;
         2: g = 6'b000000;
         3: g = {4'b0000, async_sel, 1'b0};
         6: g = 6'b000001;
         default: g = {4'b0000, async_sel, 1'b1};
      endcase
      if (m_state == 2) g[0] = 1'b1;
      cmp = (m_mode >= 2);
      return {g, m_adc, cmp, m_res};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_mode = 0; m_wait = 0; m_adc = 0; m_res = 0;
         foreach (m_hold[i]) m_hold[i] = 0;
         m_pipe = {12'd0, 12'd0};
      end else begin
         logic [11:0] ok_src;
         int d;
         foreach (m_hold[i]) ok_src[i] = (m_hold[i] >= HOLD);
         m_adc = 0; m_res = 0;
         if (m_state == 0) begin
            if (sleep_req && sleep_en) begin
               if ((ok_src & allowed(norm(mode_sel))) != 0) m_res = 1;
               else begin
                  m_state = 1;
                  m_mode  = norm(mode_sel);
                  m_adc   = adc_on && (m_mode <= 1);
               end
            end
         end else if (m_state == 1) begin
            if ((ok_src & allowed(m_mode)) != 0) begin
               d = (m_mode == 2 || m_mode == 3) ? int'(startup_dly) :
                   (m_mode >= 6) ? STBY : 0;
               if (d == 0) begin m_state = 0; m_res = 1; end
               else begin m_state = 2; m_wait = d; end
            end
         end else begin
            if (m_wait == 1) begin m_state = 0; m_res = 1; end
            else m_wait--;
         end
         foreach (m_hold[i]) m_hold[i] = m_pipe[0][i] ? m_hold[i] + 1 : 0;
         void'(m_pipe.pop_front());
         m_pipe.push_back(wake_req);
      end
   end

   function automatic string tag_of(input logic [8:0] a, input logic [8:0] e);
      if (a[0] != e[0]) return "R12";
      if (a[2] != e[2]) return "R7";
      if (a[1] != e[1]) return "R14";
      case (m_mode)
         0: return "R3";
         1: return "R4";
         2, 6: return "R5";
         default: return "R6";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [8:0] act, exp;
         act = {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async,
                osc_en, adc_start, comp_off, resume};
         exp = expect_out();
         chk(act == exp, {tag_of(act, exp), " cycle model"}, int'(act), int'(exp));
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic go_sleep(input logic [2:0] m);
      mode_sel = m; sleep_en = 1'b1; sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic time_wake(input int idx, input int exp, input string tag);
      int n = 0;
      step();
      wake_req[idx] = 1'b1;
      while (n < 100) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (resume) break;
      end
      chk(n == exp, tag, n, exp);
      step();
      wake_req[idx] = 1'b0;
      step(SYNC + 3);
   endtask

   task automatic hold_no_wake(input int idx, input int len, input string tag);
      bit woke = 0;
      step();
      wake_req[idx] = 1'b1;
      repeat (len) begin @(negedge clk); if (resume || clk_en_cpu) woke = 1; end
      chk(!woke, tag, woke, 0);
      step();
      wake_req[idx] = 1'b0;
      step(SYNC + 3);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en} == 6'h3F,
          "R1 enables", clk_en_cpu, 1);
      chk(!comp_off && !adc_start && !resume, "R1 pulses", comp_off | adc_start | resume, 0);

      // R2 strobe without permission
      step();
      mode_sel = 3'b010; sleep_en = 1'b0; sleep_req = 1'b1;
      step(); sleep_req = 1'b0;
      @(negedge clk);
      chk(clk_en_cpu && osc_en && !comp_off, "R2 ignored", clk_en_cpu, 1);

      // idle with ADC enabled
      adc_on = 1'b1;
      step();
      go_sleep(3'b000);
      chk(adc_start, "R7 idle start", adc_start, 1);
      chk(!clk_en_cpu && clk_en_io && osc_en, "R3 idle gates", clk_en_io, 1);
      time_wake(11, BASE, "R11 idle latency");

      // reserved code behaves as idle
      go_sleep(3'b101);
      chk(!clk_en_flash && clk_en_io && clk_en_async, "R3 reserved", clk_en_io, 1);
      time_wake(11, BASE, "R11 reserved latency");

      // ADC quiet mode
      go_sleep(3'b001);
      chk(adc_start, "R7 quiet start", adc_start, 1);
      chk(!clk_en_io && clk_en_adc && osc_en, "R4 quiet gates", clk_en_io, 0);
      hold_no_wake(11, 15, "R8 quiet rejects line 11");
      time_wake(7, BASE, "R8 quiet accepts ADC done");

      // deep off with start-up delay
      startup_dly = 8'd10;
      go_sleep(3'b010);
      chk(!adc_start, "R7 no start in deep off", adc_start, 0);
      chk(!osc_en && comp_off, "R5 deep off", osc_en, 0);
      chk(comp_off, "R14 deep off comparator", comp_off, 1);
      hold_no_wake(7, 15, "R8 deep off rejects ADC done");
      time_wake(4, BASE + 10, "R11 deep off latency");

      // standby
      go_sleep(3'b110);
      chk(osc_en && !clk_en_io && !clk_en_async, "R5 standby", osc_en, 1);
      time_wake(0, BASE + STBY, "R11 standby latency");

      // timer keep-alive, zero start-up delay
      startup_dly = 8'd0;
      async_sel = 1'b1; tmr_ovf_ie = 1'b1; gie = 1'b0;
      go_sleep(3'b011);
      chk(clk_en_async && !osc_en, "R6 keep-alive", clk_en_async, 1);
      hold_no_wake(9, 15, "R9 overflow needs gie");
      gie = 1'b1;
      time_wake(9, BASE, "R9 overflow wakes with gie");

      // extended standby with timer on the main clock
      async_sel = 1'b0; tmr_cmp_ie = 1'b1;
      go_sleep(3'b111);
      chk(!clk_en_async && osc_en && comp_off, "R6 extended standby", clk_en_async, 0);
      hold_no_wake(10, 15, "R9 compare needs async_sel");
      time_wake(5, BASE + STBY, "R11 extended standby latency");

      // filter threshold
      go_sleep(3'b000);
      step();
      wake_req[11] = 1'b1;
      step(HOLD - 1);
      wake_req[11] = 1'b0;
      begin
         bit woke = 0;
         repeat (15) begin @(negedge clk); if (clk_en_cpu) woke = 1; end
         chk(!woke, "R10 short pulse ignored", woke, 0);
      end
      time_wake(11, BASE, "R10 full pulse accepted");

      // pending request at strobe time
      step();
      wake_req[11] = 1'b1;
      step(SYNC + HOLD + 2);
      go_sleep(3'b000);
      chk(clk_en_cpu && resume && !adc_start, "R13 immediate resume", resume, 1);
      step();
      wake_req[11] = 1'b0;
      step(8);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule